// File: doc/BRIEF.md
# Packed OTP Logical Map Decoder

This block turns a packed one-time-programmable fuse image into a flat logical configuration map. The packed image sits in a byte-wide physical RAM that the block reads. The block first sweeps the whole logical RAM to 0xFF, one byte per cycle. It then walks a stream of records. Each record is a two-byte header followed by the 16-bit data words that the header marks as present. Each present word is copied to the logical position given by the header's block index and the word's slot number.

A run begins with a one-cycle `start` pulse while the block is idle. The walk skips a reserved area of `RSVD_SIZE` bytes at the front of the image. The same number of bytes at the tail of the image is also unusable. The walk ends normally at the first blank header or when the read index reaches the end of the usable region. It ends with an error when a word would run past the usable region or past the logical map. In every case `done` pulses for one cycle. `err` reports how the run ended and stays valid until the next start.

The physical RAM has a one-cycle read latency. The logical RAM takes one byte write per cycle. The sizes of both images and of the reserved area are parameters.

Top module: `otp_logmap_decoder`

## Requirements
- R1: After an accepted `start`, the block writes 0xFF to every logical address from 0 up to `LOG_SIZE-1`, in ascending order and one byte per cycle. It issues no physical read until this sweep is complete.
- R2: The walk starts at physical index `RSVD_SIZE`. Every physical read address lies between `RSVD_SIZE` and `PHYS_SIZE-RSVD_SIZE`, both inclusive.
- R3: A header whose first byte or second byte equals 0xFF is blank. A blank header ends the run with `done`, leaves `err` low, and copies no further words.
- R4: The 8-bit block index is formed from two nibbles. Bits 7:4 are bits 3:0 of the first header byte. Bits 3:0 are bits 7:4 of the second header byte.
- R5: Bits 3:0 of the second header byte form an active-low mask, and bit i covers slot i. Slots 0 to 3 are handled in ascending order. A slot whose bit is 1 is absent and consumes no data bytes. A present slot consumes the next two data bytes.
- R6: A present slot i is written to logical byte address block*8 + 2*i. The first data byte goes to that even address and the second byte goes to the address after it.
- R7: When the read index reaches `PHYS_SIZE-RSVD_SIZE` at a header boundary, the run ends with `done` and `err` low.
- R8: If the second byte of a present word would lie at or beyond physical index `PHYS_SIZE-RSVD_SIZE`, the run aborts. `err` is set, `done` pulses, and that word is not written. Words copied before the abort remain in the logical map.
- R9: If a present word's logical address plus 2 exceeds `LOG_SIZE`, the run aborts in the same way. A word ending exactly at `LOG_SIZE` is copied.
- R10: `done` is high for exactly one cycle per run. `err` is 0 after reset, rises only together with `done`, holds until the next accepted `start`, and is cleared by that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when the block is idle |
| phy_rd_en | output | 1 | Physical RAM read strobe |
| phy_rd_addr | output | clog2(PHYS_SIZE) | Physical RAM read address |
| phy_rd_data | input | 8 | Physical RAM read data, valid one cycle after the strobe |
| log_wr_en | output | 1 | Logical RAM write strobe |
| log_wr_addr | output | clog2(LOG_SIZE) | Logical RAM write address |
| log_wr_data | output | 8 | Logical RAM write data |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Run aborted on a bounds violation |

## Verification
The bench runs the decoder on several images, and each image separates one part of the behaviour:
- An image that is blank right after the reserved area shows that the fill and the start offset work on their own. Non-blank reserved bytes would expose a walk that started at index 0.
- A header with a blank second byte, and a full record whose block index has a non-zero upper nibble, show the nibble assembly and the byte order within a word.
- Alternating word-enable masks, and a header with no present words, show that absent slots consume no data.
- Images that end exactly at the usable end, one word past it, one word past the logical map, and exactly on the map's last word separate a clean stop from each abort.

// File: rtl/otp_logmap_pkg.sv
package otp_logmap_pkg;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;
    localparam int         LMAP_W     = 11;   // block*8 + 6 fits in 11 bits

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FILL,
        ST_HCHK,
        ST_RH2,
        ST_HDEC,
        ST_SLOT,
        ST_RD0,
        ST_WR1,
        ST_FIN
    } walk_state_e;

    typedef struct packed {
        logic       blank;
        logic [7:0] blk;
        logic [3:0] absent;
    } rec_hdr_t;

    function automatic rec_hdr_t split_header(input logic [7:0] b0, input logic [7:0] b1);
        rec_hdr_t h;
        h.blank  = (b0 == BLANK_BYTE) || (b1 == BLANK_BYTE);
        h.blk    = {b0[3:0], b1[7:4]};
        h.absent = b1[3:0];
        return h;
    endfunction

    function automatic logic [LMAP_W-1:0] slot_addr(input logic [7:0] blk, input logic [1:0] slot);
        return {blk, 3'b000} + LMAP_W'({slot, 1'b0});
    endfunction

endpackage

// File: rtl/otp_hdr_split.sv
module otp_hdr_split
    import otp_logmap_pkg::*;
(
    input  logic [7:0] first_byte,
    input  logic [7:0] second_byte,
    output rec_hdr_t   hdr
);
    always_comb hdr = split_header(first_byte, second_byte);
endmodule

// File: rtl/otp_slot_check.sv
module otp_slot_check
    import otp_logmap_pkg::*;
#(
    parameter int PHYS_SIZE = 512,
    parameter int LOG_SIZE  = 1024,
    parameter int RSVD_SIZE = 16,
    localparam int IDX_W    = $clog2(PHYS_SIZE) + 1
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        blk,
    input  logic [1:0]        slot,
    output logic [LMAP_W-1:0] laddr,
    output logic              fits_phys,
    output logic              fits_log
);
    localparam logic [IDX_W:0]  USE_END_X = (IDX_W+1)'(PHYS_SIZE - RSVD_SIZE);
    localparam logic [LMAP_W:0] LOG_LIM_X = (LMAP_W+1)'(LOG_SIZE);

    always_comb begin
        laddr     = slot_addr(blk, slot);
        fits_phys = ({1'b0, idx} + (IDX_W+1)'(2)) <= USE_END_X;
        fits_log  = ({1'b0, laddr} + (LMAP_W+1)'(2)) <= LOG_LIM_X;
    end
endmodule

// File: rtl/otp_logmap_decoder.sv
module otp_logmap_decoder
    import otp_logmap_pkg::*;
#(
    parameter int PHYS_SIZE = 512,
    parameter int LOG_SIZE  = 1024,
    parameter int RSVD_SIZE = 16,
    localparam int PA_W     = $clog2(PHYS_SIZE),
    localparam int LA_W     = $clog2(LOG_SIZE)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output logic            phy_rd_en,
    output logic [PA_W-1:0] phy_rd_addr,
    input  logic [7:0]      phy_rd_data,
    output logic            log_wr_en,
    output logic [LA_W-1:0] log_wr_addr,
    output logic [7:0]      log_wr_data,
    output logic            done,
    output logic            err
);
    localparam int              IDX_W     = PA_W + 1;
    localparam logic [IDX_W-1:0] START_IDX = IDX_W'(RSVD_SIZE);
    localparam logic [IDX_W-1:0] USE_END   = IDX_W'(PHYS_SIZE - RSVD_SIZE);
    localparam logic [LA_W-1:0]  FILL_LAST = LA_W'(LOG_SIZE - 1);

    walk_state_e        st;
    logic [LA_W-1:0]    fill_ctr;
    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   idx_p1;
    logic [7:0]         h1_q;
    logic [7:0]         blk_q;
    logic [3:0]         absent_q;
    logic [2:0]         slot;

    rec_hdr_t           hdr;
    logic [LMAP_W-1:0]  laddr;
    logic               fits_phys;
    logic               fits_log;
    logic               slot_absent;
    logic               go_copy;

    otp_hdr_split u_hdr (
        .first_byte  (h1_q),
        .second_byte (phy_rd_data),
        .hdr         (hdr)
    );

    otp_slot_check #(
        .PHYS_SIZE (PHYS_SIZE),
        .LOG_SIZE  (LOG_SIZE),
        .RSVD_SIZE (RSVD_SIZE)
    ) u_chk (
        .idx       (idx),
        .blk       (blk_q),
        .slot      (slot[1:0]),
        .laddr     (laddr),
        .fits_phys (fits_phys),
        .fits_log  (fits_log)
    );

    assign idx_p1      = idx + IDX_W'(1);
    assign slot_absent = absent_q[slot[1:0]];
    assign go_copy     = (st == ST_SLOT) && !slot[2] && !slot_absent && fits_phys && fits_log;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            fill_ctr <= '0;
            idx      <= '0;
            h1_q     <= '0;
            blk_q    <= '0;
            absent_q <= '0;
            slot     <= '0;
            err      <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    err      <= 1'b0;
                    fill_ctr <= '0;
                    st       <= ST_FILL;
                end
                ST_FILL: begin
                    if (fill_ctr == FILL_LAST) begin
                        idx <= START_IDX;
                        st  <= ST_HCHK;
                    end else begin
                        fill_ctr <= fill_ctr + LA_W'(1);
                    end
                end
                ST_HCHK: st <= (idx >= USE_END) ? ST_FIN : ST_RH2;
                ST_RH2: begin
                    h1_q <= phy_rd_data;
                    st   <= ST_HDEC;
                end
                ST_HDEC: begin
                    if (hdr.blank) begin
                        st <= ST_FIN;
                    end else begin
                        blk_q    <= hdr.blk;
                        absent_q <= hdr.absent;
                        idx      <= idx + IDX_W'(2);
                        slot     <= '0;
                        st       <= ST_SLOT;
                    end
                end
                ST_SLOT: begin
                    if (slot[2]) begin
                        st <= ST_HCHK;
                    end else if (slot_absent) begin
                        slot <= slot + 3'd1;
                    end else if (!(fits_phys && fits_log)) begin
                        err <= 1'b1;
                        st  <= ST_FIN;
                    end else begin
                        st <= ST_RD0;
                    end
                end
                ST_RD0: st <= ST_WR1;
                ST_WR1: begin
                    idx  <= idx + IDX_W'(2);
                    slot <= slot + 3'd1;
                    st   <= ST_SLOT;
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        phy_rd_en   = ((st == ST_HCHK) && (idx < USE_END)) || (st == ST_RH2) || go_copy || (st == ST_RD0);
        phy_rd_addr = ((st == ST_RH2) || (st == ST_RD0)) ? PA_W'(idx_p1) : PA_W'(idx);
        log_wr_en   = (st == ST_FILL) || (st == ST_RD0) || (st == ST_WR1);
        case (st)
            ST_FILL: log_wr_addr = fill_ctr;
            ST_WR1:  log_wr_addr = LA_W'(laddr | LMAP_W'(1));
            default: log_wr_addr = LA_W'(laddr);
        endcase
        log_wr_data = (st == ST_FILL) ? BLANK_BYTE : phy_rd_data;
        done        = (st == ST_FIN);
    end

endmodule

// File: rtl/otp_logmap_decoder_chk.sv
module otp_logmap_decoder_chk #(
    parameter int PHYS_SIZE = 512,
    parameter int LOG_SIZE  = 1024,
    parameter int RSVD_SIZE = 16,
    localparam int PA_W     = $clog2(PHYS_SIZE),
    localparam int LA_W     = $clog2(LOG_SIZE),
    localparam int WC_W     = $clog2(LOG_SIZE + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            phy_rd_en,
    input logic [PA_W-1:0] phy_rd_addr,
    input logic            log_wr_en,
    input logic [LA_W-1:0] log_wr_addr,
    input logic [7:0]      log_wr_data,
    input logic            done,
    input logic            err
);
    localparam logic [WC_W-1:0] WC_LIM = WC_W'(LOG_SIZE);
    localparam logic [PA_W-1:0] RD_LO  = PA_W'(RSVD_SIZE);
    localparam logic [PA_W-1:0] RD_HI  = PA_W'(PHYS_SIZE - RSVD_SIZE);

    logic            seen_rd;
    logic [WC_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst || done) begin
            seen_rd <= 1'b0;
            wcnt    <= '0;
        end else begin
            if (phy_rd_en) seen_rd <= 1'b1;
            if (log_wr_en && !seen_rd && wcnt != WC_LIM) wcnt <= wcnt + WC_W'(1);
        end
    end

    // R1: sweep writes carry the blank value
    p_fill_ff_r1: assert property (@(posedge clk) disable iff (rst)
        (log_wr_en && !seen_rd) |-> (log_wr_data == 8'hFF));

    // R1: the first physical read comes only after the full sweep
    p_fill_before_parse_r1: assert property (@(posedge clk) disable iff (rst)
        (phy_rd_en && !seen_rd) |-> (wcnt == WC_LIM));

    // R2: reads stay inside the usable window
    p_read_window_r2: assert property (@(posedge clk) disable iff (rst)
        phy_rd_en |-> (phy_rd_addr >= RD_LO && phy_rd_addr <= RD_HI));

    // R10: done is a one-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: err rises only together with done
    p_err_at_done_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

    // R10: err clears only after a start
    p_err_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(err) |-> $past(start));

    logic [LA_W-1:0] unused_addr;
    assign unused_addr = log_wr_addr;

endmodule

bind otp_logmap_decoder otp_logmap_decoder_chk #(
    .PHYS_SIZE (PHYS_SIZE),
    .LOG_SIZE  (LOG_SIZE),
    .RSVD_SIZE (RSVD_SIZE)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .phy_rd_en   (phy_rd_en),
    .phy_rd_addr (phy_rd_addr),
    .log_wr_en   (log_wr_en),
    .log_wr_addr (log_wr_addr),
    .log_wr_data (log_wr_data),
    .done        (done),
    .err         (err)
);

// File: tb/otp_logmap_decoder_tb_top.sv
`timescale 1ns/1ps
module otp_logmap_decoder_tb_top;
    localparam int PH   = 64;
    localparam int LG   = 256;
    localparam int RS   = 4;
    localparam int PA_W = $clog2(PH);
    localparam int LA_W = $clog2(LG);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            phy_rd_en;
    logic [PA_W-1:0] phy_rd_addr;
    logic [7:0]      phy_q = 8'h00;
    logic            log_wr_en;
    logic [LA_W-1:0] log_wr_addr;
    logic [7:0]      log_wr_data;
    logic            done;
    logic            err;

    logic [7:0] pmem [0:PH-1];
    logic [7:0] lmem [0:LG-1];
    logic [7:0] exp_map [0:LG-1];
    bit         exp_err;

    int tests = 0;
    int fails = 0;
    int wp;
    int dseed;

    int  fill_cnt;
    bit  fill_bad;
    bit  seen_rd;
    int  first_rd;
    int  done_cnt;

    always #10 clk = ~clk;

    otp_logmap_decoder #(.PHYS_SIZE(PH), .LOG_SIZE(LG), .RSVD_SIZE(RS)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .phy_rd_en   (phy_rd_en),
        .phy_rd_addr (phy_rd_addr),
        .phy_rd_data (phy_q),
        .log_wr_en   (log_wr_en),
        .log_wr_addr (log_wr_addr),
        .log_wr_data (log_wr_data),
        .done        (done),
        .err         (err)
    );

    always @(posedge clk) begin
        if (phy_rd_en) phy_q <= pmem[phy_rd_addr];
        if (log_wr_en) lmem[log_wr_addr] <= log_wr_data;
    end

    always @(negedge clk) begin
        if (log_wr_en && !seen_rd) begin
            if (int'(log_wr_addr) != fill_cnt || log_wr_data != 8'hFF) fill_bad = 1'b1;
            fill_cnt++;
        end
        if (phy_rd_en && !seen_rd) begin
            seen_rd  = 1'b1;
            first_rd = int'(phy_rd_addr);
        end
        if (done) done_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic clear_image();
        for (int i = 0; i < PH; i++) pmem[i] = 8'hFF;
        for (int i = 0; i < RS; i++) pmem[i] = 8'h00;          // reserved front, not blank
        for (int i = PH - RS; i < PH; i++) pmem[i] = 8'h00;    // reserved tail
        wp    = RS;
        dseed = 8'h20;
    endtask

    task automatic push(input logic [7:0] b);
        pmem[wp] = b;
        wp++;
    endtask

    task automatic push_words(input int n);
        for (int k = 0; k < 2 * n; k++) begin
            push(8'(dseed));
            dseed = (dseed + 7) & 8'hFF;
            if (dseed == 8'hFF) dseed = 8'h01;
        end
    endtask

    // expected map from the requirements R3..R9
    task automatic build_expected();
        int i;
        int blk;
        int la;
        logic [7:0] a;
        logic [7:0] b;
        for (int k = 0; k < LG; k++) exp_map[k] = 8'hFF;
        exp_err = 1'b0;
        i = RS;
        while (i < PH - RS) begin
            a = pmem[i];
            b = pmem[i + 1];
            if (a == 8'hFF || b == 8'hFF) return;
            blk = {a[3:0], b[7:4]};
            i += 2;
            for (int s = 0; s < 4; s++) begin
                if (b[s]) continue;
                la = blk * 8 + s * 2;
                if (i + 2 > PH - RS || la + 2 > LG) begin
                    exp_err = 1'b1;
                    return;
                end
                exp_map[la]     = pmem[i];
                exp_map[la + 1] = pmem[i + 1];
                i += 2;
            end
        end
    endtask

    task automatic run_and_check(input string req);
        int cyc;
        int bad;
        int first_bad;
        build_expected();
        for (int k = 0; k < LG; k++) lmem[k] = 8'h5A;
        fill_cnt = 0;
        fill_bad = 1'b0;
        seen_rd  = 1'b0;
        first_rd = -1;
        done_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (done_cnt == 0 && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done_cnt != 0, req, "run timed out, done count", done_cnt, 1);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R10", "done pulse cycles", done_cnt, 1);
        chk(err == exp_err, req, "err flag", int'(err), int'(exp_err));
        chk(!fill_bad && fill_cnt >= LG, "R1", "fill sweep bytes in order", fill_cnt, LG);
        chk(first_rd == RS, "R2", "first physical read address", first_rd, RS);
        bad = 0;
        first_bad = -1;
        for (int k = 0; k < LG; k++) begin
            if (lmem[k] !== exp_map[k]) begin
                bad++;
                if (first_bad < 0) first_bad = k;
            end
        end
        chk(bad == 0, req, "logical map mismatches", bad, 0);
        if (bad != 0)
            $display("  first mismatch at %0d: actual %0h expected %0h", first_bad, lmem[first_bad], exp_map[first_bad]);
    endtask

    task automatic t_reset();
        chk(done == 1'b0, "R10", "done after reset", int'(done), 0);
        chk(err == 1'b0, "R10", "err after reset", int'(err), 0);
        chk(phy_rd_en == 1'b0 && log_wr_en == 1'b0, "R1", "strobes idle after reset", int'(phy_rd_en) + int'(log_wr_en), 0);
    endtask

    task automatic t_blank_first();   // R3, R1, R2
        clear_image();
        run_and_check("R3");
    endtask

    task automatic t_second_blank();  // R3
        clear_image();
        push(8'h00); push(8'h1F - 8'h1F + 8'h10); push_words(4);  // block 1 full
        push(8'h00); push(8'hFF);
        push(8'h00); push(8'h20); push_words(4);                  // must not be copied
        run_and_check("R3");
        chk(lmem[16] == 8'hFF, "R3", "block 2 untouched after blank header", int'(lmem[16]), 255);
    endtask

    task automatic t_full_block();    // R4, R6
        clear_image();
        push(8'h01); push(8'h30);
        push(8'hA1); push(8'hA2); push(8'hB1); push(8'hB2);
        push(8'hC1); push(8'hC2); push(8'hD1); push(8'hD2);
        run_and_check("R4");
        chk(lmem[152] == 8'hA1, "R6", "slot 0 low byte at 0x13*8", int'(lmem[152]), 8'hA1);
        chk(lmem[159] == 8'hD2, "R6", "slot 3 high byte", int'(lmem[159]), 8'hD2);
    endtask

    task automatic t_sparse();        // R5, R9 boundary
        clear_image();
        push(8'h00); push(8'h2A); push_words(2);   // slots 0,2 of block 2
        push(8'h00); push(8'h55); push_words(2);   // slots 1,3 of block 5
        push(8'h01); push(8'hF7); push(8'hE1); push(8'hE2); // block 0x1F slot 3 -> 254
        run_and_check("R5");
        chk(lmem[18] == 8'hFF, "R5", "absent slot 1 of block 2 stays blank", int'(lmem[18]), 255);
        chk(lmem[255] == 8'hE2, "R9", "word ending at map end copied", int'(lmem[255]), 8'hE2);
    endtask

    task automatic t_phys_end();      // R7, R5 zero-word header
        clear_image();
        for (int b = 0; b < 5; b++) begin
            push(8'h00); push(8'(b << 4)); push_words(4);
        end
        push(8'h00); push(8'h5E); push_words(1);
        push(8'h00); push(8'h6F);
        run_and_check("R7");
    endtask

    task automatic t_phys_over();     // R8
        clear_image();
        for (int b = 0; b < 5; b++) begin
            push(8'h00); push(8'(b << 4)); push_words(4);
        end
        push(8'h00); push(8'h5E); push_words(1);
        push(8'h00); push(8'h6E);
        run_and_check("R8");
        chk(lmem[48] == 8'hFF, "R8", "word past usable end not written", int'(lmem[48]), 255);
    endtask

    task automatic t_log_over();      // R9, R10 err hold and clear
        clear_image();
        push(8'h00); push(8'h3E); push_words(1);
        push(8'h02); push(8'h00); push_words(4);   // block 0x20 -> address 256
        run_and_check("R9");
        repeat (5) @(negedge clk);
        chk(err == 1'b1, "R10", "err held while idle", int'(err), 1);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(err == 1'b0, "R10", "err cleared by start", int'(err), 0);
        repeat (LG + 20) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        tests++;
        $display("FAIL R10 watchdog: actual no finish, expected finish within %0d cycles", 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < PH; i++) pmem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_blank_first();
        t_second_blank();
        t_full_block();
        t_sparse();
        t_phys_end();
        t_phys_over();
        t_log_over();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule